// File: doc/BRIEF.md
# DMA Interrupt and Error Status Unit

This block holds the global control word and the interrupt bookkeeping of a multi-channel DMA engine. Each channel reports a completion pulse and four kinds of error pulse: burst timeout, request timeout, transfer error and buffer overflow. The unit latches these pulses into sticky per-channel status bits that software clears by writing 1. It drives two interrupt lines. The completion line is raised by any unmasked status bit. The error line is raised by any pending error bit. An error pulse also sets the channel's ordinary status bit, so software clears both bits together.

The control word carries the global DMA enable and a soft-reset bit. The soft-reset bit clears every sticky bit and masks every channel, then drops by itself after one cycle. A separate word holds the burst-timeout setting, an enable and a 15-bit count, and hands it to the timeout counters, which live outside this block. Software reaches the unit through a simple 32-bit register port. Reads are combinational. A write takes effect at the clock edge where it is presented.

The event inputs are single-cycle pulses with no handshake. The register port has no wait states and no back-pressure, because every access completes in the cycle it is presented. All pins are therefore plain control and status signals.

Top module: `dma_irq_status_unit`

## Requirements
- R1: The control word is at byte offset 0x00. Bit 0 is the global enable. It is written directly, read back in bit 0 and driven on `dma_enable`. Other written bits are ignored, and bits 31:2 read 0.
- R2: Writing 1 to control bit 1 sets a soft-reset pulse. The pulse reads back as control bit 1 for exactly one cycle. At the next edge it clears the status word and all four error words and sets the mask word to all ones. Events arriving in that pulse cycle are discarded. A second write during the pulse does not extend it. The enable bit is kept.
- R3: The status word is at offset 0x04, with bit n for channel n. A `done_evt` pulse sets the bit. Writing 1 clears the bit, and writing 0 leaves it unchanged.
- R4: The mask word is at offset 0x08. It is read/write, with bit n masking channel n when 1.
- R5: `irq_done` is high whenever some status bit is set and its mask bit is 0.
- R6: The four error words are burst timeout at 0x0C, request timeout at 0x10, transfer error at 0x14 and buffer overflow at 0x18. An event pulse sets the matching bit in its own word and the channel's bit in the status word. Each error word is cleared by writing 1.
- R7: `irq_err` is high whenever any bit of any of the four error words is set.
- R8: When an event sets a bit in the same cycle that a write of 1 clears it, the bit ends up set. Other bits cleared by the same write are cleared.
- R9: The burst-timeout word is at offset 0x1C. Bit 15 drives `burst_to_enable`, bits 14:0 drive `burst_to_count`, and bits 31:16 read 0.
- R10: Register bits at and above channel count NCH read 0. Offsets other than the eight listed, including any with address bits above bit 4 set, read 0 and ignore writes. Address bits 1:0 are not decoded.
- R11: After `rst_n` the enable, status, error and burst-timeout words are 0, the mask word is all ones and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access valid this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| done_evt | input | NCH | Per-channel completion pulses |
| burst_to_evt | input | NCH | Per-channel burst-timeout pulses |
| req_to_evt | input | NCH | Per-channel request-timeout pulses |
| xfer_err_evt | input | NCH | Per-channel transfer-error pulses |
| buf_ovf_evt | input | NCH | Per-channel buffer-overflow pulses |
| dma_enable | output | 1 | Global enable |
| burst_to_enable | output | 1 | Burst-timeout enable |
| burst_to_count | output | 15 | Burst-timeout count |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Event pulses and register writes are captured at the edge where they are presented. The status bits, register read-back and both interrupt lines reflect them one cycle later. The soft-reset pulse is visible on read-back in that first cycle, and its clearing effect appears one cycle after that. The bench drives every input at the falling edge and holds it for one full cycle. It reads the combinational read port and the interrupt pins at the next falling edge, so each check falls exactly one edge after its stimulus. The soft-reset case is checked at both of its two edges, including the cycle where the pulse bit is still visible.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int REG_W      = 32;
  localparam int ERR_KINDS  = 4;
  localparam int WORDS      = 8;
  localparam int WIX_W      = 3;
  localparam int CTRL_EN    = 0;
  localparam int CTRL_SRST  = 1;
  localparam int BTO_EN_BIT = 15;
  localparam int BTO_CNT_W  = 15;

  // Word index = byte offset / 4; the error words follow one another
  // in the order burst timeout, request timeout, transfer error, overflow.
  typedef enum logic [WIX_W-1:0] {
    WIX_CTRL  = 3'd0,
    WIX_STAT  = 3'd1,
    WIX_MASK  = 3'd2,
    WIX_ERR0  = 3'd3,
    WIX_ERR1  = 3'd4,
    WIX_ERR2  = 3'd5,
    WIX_ERR3  = 3'd6,
    WIX_BTO   = 3'd7
  } word_ix_e;
endpackage

// File: rtl/dmairq_bus_decode.sv
module dmairq_bus_decode
  import dmairq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [WORDS-1:0]  wr_stb,
  output logic              rd_hit,
  output word_ix_e          rd_ix
);
  localparam int LO = 2;
  localparam int HI = LO + WIX_W;

  logic in_window;

  generate
    if (ADDR_W > HI) begin : g_upper
      assign in_window = (reg_addr[ADDR_W-1:HI] == '0);
    end else begin : g_noupper
      assign in_window = 1'b1;
    end
  endgenerate

  assign rd_ix  = word_ix_e'(reg_addr[HI-1:LO]);
  assign rd_hit = reg_en && in_window;

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_stb
      assign wr_stb[w] = reg_en && reg_we && in_window && (reg_addr[HI-1:LO] == WIX_W'(w));
    end
  endgenerate
endmodule

// File: rtl/dmairq_w1c_bank.sv
module dmairq_w1c_bank #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           srst,
  input  logic [NCH-1:0] set_i,
  input  logic           clr_stb,
  input  logic [NCH-1:0] clr_bits,
  output logic [NCH-1:0] q
);
  logic [NCH-1:0] clr_eff;

  assign clr_eff = clr_stb ? clr_bits : '0;

  // Soft reset dominates; otherwise a set beats a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (srst) q <= '0;
    else           q <= (q & ~clr_eff) | set_i;
  end
endmodule

// File: rtl/dmairq_cfg_regs.sv
module dmairq_cfg_regs
  import dmairq_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 wr_ctrl,
  input  logic                 wr_mask,
  input  logic                 wr_bto,
  output logic                 dma_en,
  output logic                 srst,
  output logic [NCH-1:0]       mask_q,
  output logic                 bto_en,
  output logic [BTO_CNT_W-1:0] bto_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en <= 1'b0;
      srst   <= 1'b0;
    end else begin
      if (wr_ctrl) dma_en <= wdata[CTRL_EN];
      srst <= wr_ctrl && wdata[CTRL_SRST] && !srst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (srst)    mask_q <= '1;
    else if (wr_mask) mask_q <= wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bto_en  <= 1'b0;
      bto_cnt <= '0;
    end else if (wr_bto) begin
      bto_en  <= wdata[BTO_EN_BIT];
      bto_cnt <= wdata[BTO_CNT_W-1:0];
    end
  end
endmodule

// File: rtl/dma_irq_status_unit.sv
module dma_irq_status_unit
  import dmairq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NCH-1:0]       done_evt,
  input  logic [NCH-1:0]       burst_to_evt,
  input  logic [NCH-1:0]       req_to_evt,
  input  logic [NCH-1:0]       xfer_err_evt,
  input  logic [NCH-1:0]       buf_ovf_evt,
  output logic                 dma_enable,
  output logic                 burst_to_enable,
  output logic [14:0]          burst_to_count,
  output logic                 irq_done,
  output logic                 irq_err
);
  logic [WORDS-1:0]               wr_stb;
  logic                           rd_hit;
  word_ix_e                       rd_ix;
  logic                           srst;
  logic [NCH-1:0]                 mask_q;
  logic [NCH-1:0]                 stat_q;
  logic [NCH-1:0]                 stat_set;
  logic [ERR_KINDS-1:0][NCH-1:0]  err_set;
  logic [ERR_KINDS-1:0][NCH-1:0]  err_q;
  logic [ERR_KINDS-1:0]           err_pend;

  dmairq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .reg_en   (reg_en),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wr_stb   (wr_stb),
    .rd_hit   (rd_hit),
    .rd_ix    (rd_ix)
  );

  dmairq_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdata   (reg_wdata),
    .wr_ctrl (wr_stb[WIX_CTRL]),
    .wr_mask (wr_stb[WIX_MASK]),
    .wr_bto  (wr_stb[WIX_BTO]),
    .dma_en  (dma_enable),
    .srst    (srst),
    .mask_q  (mask_q),
    .bto_en  (burst_to_enable),
    .bto_cnt (burst_to_count)
  );

  assign err_set[0] = burst_to_evt;
  assign err_set[1] = req_to_evt;
  assign err_set[2] = xfer_err_evt;
  assign err_set[3] = buf_ovf_evt;

  generate
    for (genvar k = 0; k < ERR_KINDS; k++) begin : g_err
      dmairq_w1c_bank #(.NCH(NCH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .set_i    (err_set[k]),
        .clr_stb  (wr_stb[int'(WIX_ERR0) + k]),
        .clr_bits (reg_wdata[NCH-1:0]),
        .q        (err_q[k])
      );
      assign err_pend[k] = |err_q[k];
    end
  endgenerate

  always_comb begin
    stat_set = done_evt;
    for (int k = 0; k < ERR_KINDS; k++) stat_set = stat_set | err_set[k];
  end

  dmairq_w1c_bank #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (srst),
    .set_i    (stat_set),
    .clr_stb  (wr_stb[WIX_STAT]),
    .clr_bits (reg_wdata[NCH-1:0]),
    .q        (stat_q)
  );

  assign irq_done = |(stat_q & ~mask_q);
  assign irq_err  = |err_pend;

  always_comb begin
    reg_rdata = '0;
    if (rd_hit) begin
      unique case (rd_ix)
        WIX_CTRL: begin
          reg_rdata[CTRL_EN]   = dma_enable;
          reg_rdata[CTRL_SRST] = srst;
        end
        WIX_STAT: reg_rdata[NCH-1:0] = stat_q;
        WIX_MASK: reg_rdata[NCH-1:0] = mask_q;
        WIX_ERR0: reg_rdata[NCH-1:0] = err_q[0];
        WIX_ERR1: reg_rdata[NCH-1:0] = err_q[1];
        WIX_ERR2: reg_rdata[NCH-1:0] = err_q[2];
        WIX_ERR3: reg_rdata[NCH-1:0] = err_q[3];
        WIX_BTO: begin
          reg_rdata[BTO_EN_BIT]       = burst_to_enable;
          reg_rdata[BTO_CNT_W-1:0]    = burst_to_count;
        end
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmairq_checker.sv
module dmairq_checker
  import dmairq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_en,
  input logic                          reg_we,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [31:0]                   reg_rdata,
  input logic [NCH-1:0]                done_evt,
  input logic [NCH-1:0]                burst_to_evt,
  input logic [NCH-1:0]                req_to_evt,
  input logic [NCH-1:0]                xfer_err_evt,
  input logic [NCH-1:0]                buf_ovf_evt,
  input logic                          srst,
  input logic [NCH-1:0]                stat_q,
  input logic [NCH-1:0]                mask_q,
  input logic [ERR_KINDS-1:0][NCH-1:0] err_q,
  input logic                          irq_done,
  input logic                          irq_err
);
  logic [NCH-1:0] err_any;
  assign err_any = burst_to_evt | req_to_evt | xfer_err_evt | buf_ovf_evt;

  assert_srst_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst);

  assert_srst_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (stat_q == '0 && err_q == '0 && mask_q == '1));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && |done_evt) |=> ((stat_q & $past(done_evt)) == $past(done_evt)));

  assert_err_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && |err_any) |=> ((stat_q & $past(err_any)) == $past(err_any)));

  assert_irq_err_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && |err_any) |=> irq_err);

  assert_irq_done_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && !(reg_en && reg_we) && |(done_evt & ~mask_q)) |=> irq_done);

  assert_bto_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we && reg_addr == ADDR_W'(28)) |-> (reg_rdata[31:16] == 16'h0));
endmodule

bind dma_irq_status_unit dmairq_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_en       (reg_en),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .done_evt     (done_evt),
  .burst_to_evt (burst_to_evt),
  .req_to_evt   (req_to_evt),
  .xfer_err_evt (xfer_err_evt),
  .buf_ovf_evt  (buf_ovf_evt),
  .srst         (srst),
  .stat_q       (stat_q),
  .mask_q       (mask_q),
  .err_q        (err_q),
  .irq_done     (irq_done),
  .irq_err      (irq_err)
);

// File: tb/dma_irq_status_unit_bench.sv
module dma_irq_status_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH    = 16;
  localparam int ADDR_W = 8;

  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_MASK = 8'h08,
                         A_BTO  = 8'h1C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_en = 1'b0, reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NCH-1:0]    done_evt = '0, burst_to_evt = '0, req_to_evt = '0,
                     xfer_err_evt = '0, buf_ovf_evt = '0;
  logic              dma_enable, burst_to_enable, irq_done, irq_err;
  logic [14:0]       burst_to_count;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status_unit #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dma_irq_status_unit (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  // kind: 0..3 error words in offset order, 4 = completion
  task automatic pulse(input int kind, input logic [NCH-1:0] bits);
    @(negedge clk);
    case (kind)
      0: burst_to_evt = bits;
      1: req_to_evt   = bits;
      2: xfer_err_evt = bits;
      3: buf_ovf_evt  = bits;
      default: done_evt = bits;
    endcase
    @(negedge clk);
    burst_to_evt = '0; req_to_evt = '0; xfer_err_evt = '0; buf_ovf_evt = '0; done_evt = '0;
  endtask

  task automatic t_reset;
    read_check("R11 ctrl", A_CTRL, 32'h0);
    read_check("R11 status", A_STAT, 32'h0);
    read_check("R11 mask", A_MASK, 32'h0000FFFF);
    for (int k = 0; k < 4; k++) read_check("R11 err word", 8'(12 + 4*k), 32'h0);
    read_check("R11 bto", A_BTO, 32'h0);
    check("R11 irqs", {30'h0, irq_done, irq_err}, 32'h0);
  endtask

  task automatic t_ctrl;
    bus_write(A_CTRL, 32'h1);
    read_check("R1 enable readback", A_CTRL, 32'h1);
    check("R1 dma_enable", {31'h0, dma_enable}, 32'h1);
    bus_write(A_CTRL, 32'hFFFF_FFF1);
    read_check("R1 upper bits ignored", A_CTRL, 32'h1);
    bus_write(A_CTRL, 32'h0);
    check("R1 disable", {31'h0, dma_enable}, 32'h0);
  endtask

  task automatic t_done;
    pulse(4, 16'h0004);
    read_check("R3 done sets bit", A_STAT, 32'h4);
    check("R5 masked no irq", {31'h0, irq_done}, 32'h0);
    bus_write(A_MASK, 32'h0000_FFFB);
    read_check("R4 mask readback", A_MASK, 32'h0000FFFB);
    check("R5 unmasked irq", {31'h0, irq_done}, 32'h1);
    bus_write(A_STAT, 32'h0);
    read_check("R3 write 0 keeps", A_STAT, 32'h4);
    bus_write(A_STAT, 32'h4);
    read_check("R3 w1c", A_STAT, 32'h0);
    check("R5 irq drops", {31'h0, irq_done}, 32'h0);
    pulse(4, 16'h8000);
    read_check("R3 top channel", A_STAT, 32'h8000);
    bus_write(A_STAT, 32'h8000);
    bus_write(A_MASK, 32'h0000_FFFF);
  endtask

  task automatic t_errors;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] b;
      b = 16'(1 << (k + 8));
      pulse(k, b);
      for (int j = 0; j < 4; j++)
        read_check("R6 error word", 8'(12 + 4*j), (j == k) ? {16'h0, b} : 32'h0);
      read_check("R6 status also set", A_STAT, {16'h0, b});
      check("R7 irq_err high", {31'h0, irq_err}, 32'h1);
      bus_write(8'(12 + 4*k), {16'h0, b});
      bus_write(A_STAT, {16'h0, b});
      read_check("R6 error w1c", 8'(12 + 4*k), 32'h0);
      read_check("R6 status w1c", A_STAT, 32'h0);
      check("R7 irq_err low", {31'h0, irq_err}, 32'h0);
    end
  endtask

  task automatic t_set_wins;
    pulse(4, 16'h0020);
    @(negedge clk);
    done_evt = 16'h0008;
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h28;
    @(negedge clk);
    done_evt = '0; reg_en = 1'b0; reg_we = 1'b0;
    read_check("R8 set beats clear", A_STAT, 32'h8);
    @(negedge clk);
    buf_ovf_evt = 16'h0001;
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = 8'h18; reg_wdata = 32'h1;
    @(negedge clk);
    buf_ovf_evt = '0; reg_en = 1'b0; reg_we = 1'b0;
    read_check("R8 error set beats clear", 8'h18, 32'h1);
    bus_write(8'h18, 32'h1);
    bus_write(A_STAT, 32'h9);
    read_check("R8 cleanup", A_STAT, 32'h0);
  endtask

  task automatic t_srst;
    pulse(4, 16'h0002);
    pulse(2, 16'h0001);
    bus_write(A_MASK, 32'h0);
    bus_write(A_CTRL, 32'h3);
    read_check("R2 pulse visible", A_CTRL, 32'h3);
    read_check("R2 not yet cleared", A_STAT, 32'h3);
    @(negedge clk);
    read_check("R2 pulse self-clears", A_CTRL, 32'h1);
    read_check("R2 status cleared", A_STAT, 32'h0);
    read_check("R2 error cleared", 8'h14, 32'h0);
    read_check("R2 mask all ones", A_MASK, 32'h0000FFFF);
    check("R2 irqs low", {30'h0, irq_done, irq_err}, 32'h0);
    check("R2 enable kept", {31'h0, dma_enable}, 32'h1);
  endtask

  task automatic t_bto;
    bus_write(A_BTO, 32'hFFFF_ABCD);
    read_check("R9 bto readback", A_BTO, 32'h0000ABCD);
    check("R9 bto enable", {31'h0, burst_to_enable}, 32'h1);
    check("R9 bto count", {17'h0, burst_to_count}, 32'h2BCD);
    bus_write(A_BTO, 32'h7);
    check("R9 bto disabled", {31'h0, burst_to_enable}, 32'h0);
    check("R9 bto count 7", {17'h0, burst_to_count}, 32'h7);
  endtask

  task automatic t_range;
    bus_write(A_MASK, 32'hFFFF_0000);
    read_check("R10 bits above NCH", A_MASK, 32'h0);
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_write(8'h48, 32'hFFFF_FFFF);
    read_check("R10 unmapped write ignored", A_MASK, 32'h0);
    read_check("R10 unmapped reads 0", 8'h24, 32'h0);
    read_check("R10 high alias reads 0", 8'h48, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_done();
    t_errors();
    t_set_wins();
    t_srst();
    t_bto();
    t_range();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule